// File: doc/BRIEF.md
# Dual-Bank Firmware Update Controller

This block maintains two firmware images for a downstream management controller (the target) in four external SPI flash devices. Two devices form each bank. One bank, the active one, always holds the image the target is running. Host program and erase commands are steered to the other bank, the standby bank, so the target keeps running while a new image is written. A commit command streams the standby bank into the target's configuration port. The target is held in reset for the whole load. The new image becomes active only when its 8-bit byte sum is zero.

If a committed image fails that check, the controller reloads the preserved active image without host help and reports the fallback. The block also runs a watchdog on the target. Each timeout gives a one-cycle reset pulse and adds one to a fault counter. Three timeouts in a row with no kick between them trigger a fallback load from the standby bank. The active-bank flag starts from a strap input at reset and changes only when a verified load completes. A power loss part-way through an update therefore leaves the old bank selected.

Top module: `fw_bank_ctrl`

## Requirements
- R1: After reset, `busy`, `err_code`, `rolled` and `fault_cnt` are zero and `act_bank` equals `boot_bank`. `tgt_rst_n` is high, `cfg_valid` is low and all four `spi_cs_n` lines are high.
- R2: The SPI interface uses mode 0 with `spi_sclk` running at one quarter of `clk`. Bytes are sent MSB first, and `spi_sclk` is low whenever no chip select is active. Each transaction starts with an opcode: 0x03 read, 0x02 page program, 0xD8 sector erase, 0x05 status read. Read, program and erase send three address bytes after the opcode, carrying the device-local address zero-extended.
- R3: Program (`cmd_op`=0) and erase (`cmd_op`=1) always act on the standby bank (not `act_bank`). The selected device is `spi_cs_n[2*bank + addr[BANK_AW-1]]`, and the low `BANK_AW-1` address bits go to that device. The active bank's devices are never written.
- R4: After a program or erase, the controller repeats 0x05 status reads on the same device until bit 0 of the status byte is 0. `busy` stays high until that status read ends.
- R5: A commit (`cmd_op`=2) reads standby-bank bytes 0 to `IMG_BYTES`-1 in order. It restarts the read on the second device when the address crosses bit `BANK_AW-1`. Each byte appears on `cfg_data` with a one-cycle `cfg_valid`.
- R6: `tgt_rst_n` is low for the whole of any load, including every cycle in which `cfg_valid` is high.
- R7: `act_bank` changes only at the end of a load whose bytes sum to 0 modulo 256. A commit that verifies this way sets `act_bank` to the loaded bank and clears `err_code` and `rolled`.
- R8: If a committed image fails the sum check, the controller at once reloads the active bank. When that reload verifies, `act_bank` is unchanged, `err_code`=1 and `rolled`=1.
- R9: With `wd_en` high and no load running, `wd_limit` cycles without `wd_kick` produce a one-cycle low pulse on `tgt_rst_n`. Each such pulse adds one to `fault_cnt`, which saturates at 255.
- R10: `wd_kick` clears both the watchdog count and the count of consecutive timeouts. The third consecutive timeout starts a load from the standby bank. When that load verifies, `act_bank` switches, `err_code`=2 and `rolled`=1.
- R11: If a fallback load also fails the sum check, `err_code`=3 and `tgt_rst_n` stays low.
- R12: At most one `spi_cs_n` line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_bank | input | 1 | Active bank to use after reset |
| cmd_valid | input | 1 | Host command strobe, taken when not busy |
| cmd_op | input | 2 | 0 program byte, 1 erase sector, 2 commit standby image |
| cmd_addr | input | BANK_AW | Bank-local byte address |
| cmd_data | input | 8 | Byte to program |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |
| spi_cs_n | output | 4 | Per-device chip selects, active low |
| cfg_valid | output | 1 | Configuration byte strobe to target |
| cfg_data | output | 8 | Configuration byte |
| tgt_rst_n | output | 1 | Target reset, active low |
| wd_en | input | 1 | Watchdog enable |
| wd_kick | input | 1 | Watchdog kick from target |
| wd_limit | input | WD_W | Timeout length in cycles |
| busy | output | 1 | Command or load in progress |
| act_bank | output | 1 | Active bank |
| err_code | output | 2 | 0 ok, 1 update fell back, 2 watchdog fallback, 3 fallback image bad |
| rolled | output | 1 | Last completed load was a fallback |
| fault_cnt | output | 8 | Watchdog timeouts, saturating |

## Verification
`busy` rises one cycle after a command is taken. A load delivers one `cfg_valid` pulse every 32 clocks. `act_bank`, `err_code` and `rolled` update one cycle after the last configuration byte, at the same edge where `busy` falls. A watchdog pulse appears exactly `wd_limit` edges after the edge that samples a kick. The bench drives inputs and samples outputs on falling edges. It waits on `busy` instead of counting fixed delays for SPI traffic. It counts edges from the kick when timing the watchdog. A flash model in the bench checks each byte written and the clock spacing as the transfer runs.

// File: rtl/fw_bank_ctrl.sv
module fw_bank_ctrl #(
  parameter int BANK_AW   = 19,
  parameter int IMG_BYTES = 524288,
  parameter int WD_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_bank,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [BANK_AW-1:0] cmd_addr,
  input  logic [7:0]         cmd_data,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic [3:0]         spi_cs_n,
  output logic               cfg_valid,
  output logic [7:0]         cfg_data,
  output logic               tgt_rst_n,
  input  logic               wd_en,
  input  logic               wd_kick,
  input  logic [WD_W-1:0]    wd_limit,
  output logic               busy,
  output logic               act_bank,
  output logic [1:0]         err_code,
  output logic               rolled,
  output logic [7:0]         fault_cnt
);
  localparam int CW = $clog2(IMG_BYTES + 1);
  localparam int LW = BANK_AW - 1;

  typedef enum logic [1:0] {K_PROG, K_ERASE, K_POLL, K_READ} kind_t;
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_FIN} st_t;

  st_t               st;
  kind_t             kind, nxt;
  logic [1:0]        ph;
  logic [2:0]        bitc, bidx;
  logic [7:0]        txs, rxs, wdat, sum;
  logic [BANK_AW-1:0] a;
  logic              bk;
  logic [CW-1:0]     cnt;
  logic              loading, rbload, rb_wd;
  logic [WD_W-1:0]   wcnt;
  logic [1:0]        consec;
  logic              rb_pend, wd_pulse;

  logic [23:0] dev_addr;
  logic [2:0]  bidx_n;
  logic        wd_run;

  function automatic logic [7:0] op_code(kind_t k);
    case (k)
      K_PROG:  return 8'h02;
      K_ERASE: return 8'hD8;
      K_POLL:  return 8'h05;
      default: return 8'h03;
    endcase
  endfunction

  function automatic logic [7:0] tx_byte(kind_t k, logic [2:0] idx, logic [23:0] da, logic [7:0] d);
    case (idx)
      3'd0:    return op_code(k);
      3'd1:    return da[23:16];
      3'd2:    return da[15:8];
      3'd3:    return da[7:0];
      default: return (k == K_PROG) ? d : 8'h00;
    endcase
  endfunction

  assign dev_addr  = 24'(a[LW-1:0]);
  assign bidx_n    = (bidx == 3'd4) ? 3'd4 : bidx + 3'd1;
  assign wd_run    = wd_en & ~loading & (err_code != 2'd3);
  assign busy      = (st != S_IDLE);
  assign spi_sclk  = (st == S_SHIFT) & ph[1];
  assign spi_mosi  = txs[7];
  assign tgt_rst_n = ~(loading | wd_pulse | (err_code == 2'd3));

  always_comb begin
    spi_cs_n = '1;
    if (st == S_SHIFT) spi_cs_n[{bk, a[LW]}] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;   kind <= K_READ;  nxt <= K_READ;
      ph <= '0;       bitc <= '0;      bidx <= '0;
      txs <= '0;      rxs <= '0;       wdat <= '0;  sum <= '0;
      a <= '0;        bk <= 1'b0;      cnt <= '0;
      loading <= 1'b0; rbload <= 1'b0; rb_wd <= 1'b0;
      wcnt <= '0;     consec <= '0;    rb_pend <= 1'b0; wd_pulse <= 1'b0;
      cfg_valid <= 1'b0; cfg_data <= '0;
      act_bank <= boot_bank; err_code <= '0; rolled <= 1'b0; fault_cnt <= '0;
    end else begin
      cfg_valid <= 1'b0;
      wd_pulse  <= 1'b0;

      if (!wd_run || wd_kick) begin
        wcnt <= '0;
        if (wd_kick) consec <= '0;
      end else if (wcnt == wd_limit - 1'b1) begin
        wcnt     <= '0;
        wd_pulse <= 1'b1;
        if (fault_cnt != 8'hFF) fault_cnt <= fault_cnt + 8'd1;
        if (consec == 2'd2) begin
          consec  <= '0;
          rb_pend <= 1'b1;
        end else consec <= consec + 2'd1;
      end else wcnt <= wcnt + 1'b1;

      case (st)
        S_IDLE: begin
          if (rb_pend) begin
            rb_pend <= 1'b0;
            bk <= ~act_bank; a <= '0; cnt <= '0; sum <= '0;
            loading <= 1'b1; rbload <= 1'b1; rb_wd <= 1'b1;
            nxt <= K_READ; st <= S_GAP;
          end else if (cmd_valid) begin
            case (cmd_op)
              2'd0: begin
                bk <= ~act_bank; a <= cmd_addr; wdat <= cmd_data;
                nxt <= K_PROG; st <= S_GAP;
              end
              2'd1: begin
                bk <= ~act_bank; a <= cmd_addr;
                nxt <= K_ERASE; st <= S_GAP;
              end
              2'd2: begin
                bk <= ~act_bank; a <= '0; cnt <= '0; sum <= '0;
                loading <= 1'b1; rbload <= 1'b0; rb_wd <= 1'b0;
                nxt <= K_READ; st <= S_GAP;
              end
              default: ;
            endcase
          end
        end

        S_GAP: begin
          st   <= S_SHIFT;
          kind <= nxt;
          ph   <= '0;
          bitc <= '0;
          bidx <= '0;
          txs  <= op_code(nxt);
        end

        S_SHIFT: begin
          ph <= ph + 2'd1;
          if (ph == 2'd2) rxs <= {rxs[6:0], spi_miso};
          if (ph == 2'd3) begin
            if (bitc != 3'd7) begin
              bitc <= bitc + 3'd1;
              txs  <= {txs[6:0], 1'b0};
            end else begin
              bitc <= '0;
              bidx <= bidx_n;
              txs  <= tx_byte(kind, bidx_n, dev_addr, wdat);
              case (kind)
                K_PROG:  if (bidx == 3'd4) begin st <= S_GAP; nxt <= K_POLL; end
                K_ERASE: if (bidx == 3'd3) begin st <= S_GAP; nxt <= K_POLL; end
                K_POLL:  if (bidx == 3'd1) begin
                  if (rxs[0]) begin st <= S_GAP; nxt <= K_POLL; end
                  else st <= S_IDLE;
                end
                default: if (bidx == 3'd4) begin
                  cfg_valid <= 1'b1;
                  cfg_data  <= rxs;
                  sum       <= sum + rxs;
                  cnt       <= cnt + 1'b1;
                  a         <= a + 1'b1;
                  if (cnt == CW'(IMG_BYTES - 1)) st <= S_FIN;
                  else if (&a[LW-1:0]) begin st <= S_GAP; nxt <= K_READ; end
                end
              endcase
            end
          end
        end

        default: begin
          if (sum == 8'd0) begin
            act_bank <= bk;
            loading  <= 1'b0;
            rolled   <= rbload;
            err_code <= rbload ? (rb_wd ? 2'd2 : 2'd1) : 2'd0;
            st       <= S_IDLE;
          end else if (!rbload) begin
            bk <= act_bank; a <= '0; cnt <= '0; sum <= '0;
            rbload <= 1'b1; rb_wd <= 1'b0;
            nxt <= K_READ; st <= S_GAP;
          end else begin
            err_code <= 2'd3;
            loading  <= 1'b0;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fw_bank_ctrl_chk.sv
module fw_bank_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] spi_cs_n,
  input logic       spi_sclk,
  input logic       cfg_valid,
  input logic       busy,
  input logic       tgt_rst_n,
  input logic       act_bank,
  input logic [1:0] err_code,
  input logic [7:0] fault_cnt
);
  assert_cs_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1);

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);

  assert_cfg_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (busy && !tgt_rst_n));

  assert_act_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_bank != $past(act_bank)) |-> ($past(busy) && !busy && err_code != 2'd3));

  assert_fault_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cnt != $past(fault_cnt)) |-> (fault_cnt == $past(fault_cnt) + 8'd1));

  assert_hold_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 2'd3) |-> !tgt_rst_n);
endmodule

bind fw_bank_ctrl fw_bank_ctrl_chk u_chk (.*);

// File: tb/test_fw_bank_ctrl.sv
module test_fw_bank_ctrl;
  localparam int AW = 4;
  localparam int IMG = 16;
  localparam int DSZ = 8;

  logic clk = 1'b0, rst_n = 1'b0, boot_bank = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic spi_sclk, spi_mosi, spi_miso;
  logic [3:0] spi_cs_n;
  logic cfg_valid, tgt_rst_n, busy, act_bank, rolled;
  logic [7:0] cfg_data, fault_cnt;
  logic [1:0] err_code;
  logic wd_en = 1'b0, wd_kick = 1'b0;
  logic [7:0] wd_limit = 8'd5;

  always #2 clk = ~clk;

  fw_bank_ctrl #(.BANK_AW(AW), .IMG_BYTES(IMG), .WD_W(8)) i_fw_bank_ctrl (
    .clk, .rst_n, .boot_bank, .cmd_valid, .cmd_op, .cmd_addr, .cmd_data,
    .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n, .cfg_valid, .cfg_data,
    .tgt_rst_n, .wd_en, .wd_kick, .wd_limit, .busy, .act_bank, .err_code,
    .rolled, .fault_cnt);

  int nchk = 0, nerr = 0;
  task automatic check(string req, int actv, int expv);
    nchk++;
    if (actv != expv) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  // flash model for all four devices, sampled on falling clk edges
  logic [7:0] fmem [4*DSZ];
  int fbusy [4];
  logic sel_q = 1'b0, sclk_q = 1'b0;
  int dev = 0, bc = 0, cyc = 0, last_rise = -1, bad_gap = 0, overlap = 0;
  int npoll = 0;
  logic [7:0] sr = '0, op = '0;
  logic [23:0] ad = '0;
  logic seen02 = 0, seen03 = 0, seen05 = 0, seenD8 = 0, seen_bad = 0;
  logic miso_r = 1'b0;
  assign spi_miso = miso_r;

  logic [7:0] cap [64];
  int ncap = 0, cfg_rst_bad = 0;

  always @(negedge clk) begin
    logic sel;
    logic [7:0] stat;
    int j;
    cyc++;
    sel = ~&spi_cs_n;
    if ($countones(~spi_cs_n) > 1) overlap++;
    if (cfg_valid) begin
      cap[ncap % 64] = cfg_data;
      ncap++;
      if (tgt_rst_n) cfg_rst_bad++;
    end
    if (sel && !sel_q) begin
      bc = 0; op = 0; ad = 0; last_rise = -1; miso_r = 1'b0;
      for (int d = 0; d < 4; d++) if (!spi_cs_n[d]) dev = d;
    end
    if (!sel && sel_q) begin
      if (op == 8'h05) begin
        npoll++;
        if (fbusy[dev] > 0) fbusy[dev]--;
      end
    end
    if (sel && spi_sclk && !sclk_q) begin
      if (last_rise >= 0 && cyc - last_rise != 4) bad_gap++;
      last_rise = cyc;
      sr = {sr[6:0], spi_mosi};
      bc++;
      if (bc % 8 == 0) begin
        j = bc / 8 - 1;
        if (j == 0) begin
          op = sr;
          case (sr)
            8'h02: seen02 = 1;
            8'h03: seen03 = 1;
            8'h05: seen05 = 1;
            8'hD8: seen05 = seen05;
            default: seen_bad = 1;
          endcase
          if (sr == 8'hD8) seenD8 = 1;
        end else if (j <= 3 && op != 8'h05) ad = {ad[15:0], sr};
        if (op == 8'h02 && j == 4) begin
          fmem[dev*DSZ + int'(ad % DSZ)] = sr;
          fbusy[dev] = 2;
        end
        if (op == 8'hD8 && j == 3) begin
          for (int i = 0; i < DSZ; i++) fmem[dev*DSZ + i] = 8'hFF;
          fbusy[dev] = 3;
        end
      end
    end
    if (sel && !spi_sclk && sclk_q) begin
      if (op == 8'h03 && bc >= 32)
        miso_r = fmem[dev*DSZ + int'((ad + 24'((bc - 32) / 8)) % DSZ)][7 - (bc % 8)];
      else if (op == 8'h05 && bc >= 8) begin
        stat = {7'b0, fbusy[dev] != 0};
        miso_r = stat[7 - (bc % 8)];
      end
    end
    sel_q = sel;
    sclk_q = spi_sclk;
  end

  logic [7:0] imgB [IMG], imgC [IMG], imgD [IMG];
  logic wd_fail = 1'b0;

  task automatic wait_idle();
    int k = 0;
    @(negedge clk);
    while (busy && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) wd_fail = 1'b1;
  endtask

  task automatic host_cmd(logic [1:0] o, logic [AW-1:0] adr, logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = o; cmd_addr = adr; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic write_standby(int which);
    host_cmd(2'd1, 4'd0, 8'h00);
    host_cmd(2'd1, 4'd8, 8'h00);
    for (int i = 0; i < IMG; i++)
      host_cmd(2'd0, AW'(i), which == 0 ? imgB[i] : which == 1 ? imgC[i] : imgD[i]);
  endtask

  initial begin
    int s, p0, n;
    logic [7:0] sb, sc;
    sb = 0; sc = 0;
    for (int i = 0; i < IMG - 1; i++) begin
      imgB[i] = 8'(i * 7 + 3);  sb += imgB[i];
      imgC[i] = 8'(i * 13 + 5); sc += imgC[i];
    end
    imgB[IMG-1] = 8'(-sb); imgC[IMG-1] = 8'(-sc);
    for (int i = 0; i < IMG; i++) imgD[i] = imgB[i];
    imgD[IMG-1] = imgB[IMG-1] + 8'd1;
    for (int i = 0; i < IMG; i++) begin fmem[i] = imgC[i]; fmem[IMG + i] = 8'h55; end
    for (int d = 0; d < 4; d++) fbusy[d] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 act_bank", act_bank, 0);
    check("R1 err_code", err_code, 0);
    check("R1 rolled", rolled, 0);
    check("R1 fault_cnt", fault_cnt, 0);
    check("R1 tgt_rst_n", tgt_rst_n, 1);
    check("R1 cfg_valid", cfg_valid, 0);
    check("R1 cs_n", spi_cs_n, 4'hF);

    // R3 erase goes to standby bank, device by address bit 3
    host_cmd(2'd1, 4'd0, 8'h00);
    s = 1;
    for (int i = 0; i < DSZ; i++) if (fmem[16+i] != 8'hFF || fmem[24+i] != 8'h55) s = 0;
    check("R3 erase low device of standby", s, 1);
    host_cmd(2'd1, 4'd8, 8'h00);
    s = 1;
    for (int i = 0; i < DSZ; i++) if (fmem[24+i] != 8'hFF) s = 0;
    check("R3 erase high device of standby", s, 1);
    p0 = npoll;
    host_cmd(2'd0, 4'd0, imgB[0]);
    check("R4 status polls until ready", npoll - p0, 3);
    for (int i = 1; i < IMG; i++) host_cmd(2'd0, AW'(i), imgB[i]);
    for (int i = 0; i < IMG; i++) check($sformatf("R3 program byte %0d", i), fmem[16+i], imgB[i]);
    s = 1;
    for (int i = 0; i < IMG; i++) if (fmem[i] != imgC[i]) s = 0;
    check("R3 active bank untouched", s, 1);
    check("R2 opcode 0x02 seen", seen02, 1);
    check("R2 opcode 0xD8 seen", seenD8, 1);
    check("R4 opcode 0x05 seen", seen05, 1);

    // R5/R7 commit
    ncap = 0;
    host_cmd(2'd2, 4'd0, 8'h00);
    check("R5 byte count", ncap, IMG);
    for (int i = 0; i < IMG; i++) check($sformatf("R5 cfg byte %0d", i), cap[i], imgB[i]);
    check("R2 opcode 0x03 seen", seen03, 1);
    check("R7 act_bank after commit", act_bank, 1);
    check("R7 err_code after commit", err_code, 0);
    check("R7 rolled after commit", rolled, 0);
    check("R6 target released after load", tgt_rst_n, 1);

    // R8 bad image into bank 0, automatic fallback to bank 1
    write_standby(2);
    ncap = 0;
    host_cmd(2'd2, 4'd0, 8'h00);
    check("R8 bytes streamed", ncap, 2 * IMG);
    s = 1;
    for (int i = 0; i < IMG; i++) if (cap[i] != imgD[i] || cap[IMG+i] != imgB[i]) s = 0;
    check("R8 bad image then old image", s, 1);
    check("R8 act_bank kept", act_bank, 1);
    check("R8 err_code", err_code, 1);
    check("R8 rolled", rolled, 1);

    // R9 watchdog timing
    write_standby(1);
    wd_limit = 8'd5; wd_en = 1'b1; wd_kick = 1'b1;
    @(negedge clk);
    wd_kick = 1'b0;
    n = 0;
    for (int k = 1; k <= 20 && n == 0; k++) begin
      @(negedge clk);
      if (!tgt_rst_n) n = k;
    end
    check("R9 timeout after wd_limit cycles", n, 5);
    check("R9 fault_cnt", fault_cnt, 1);
    @(negedge clk);
    check("R9 pulse one cycle", tgt_rst_n, 1);

    // R10 kicks hold off timeouts
    s = 0;
    for (int k = 0; k < 40; k++) begin
      wd_kick = (k % 3 == 0);
      @(negedge clk);
      if (!tgt_rst_n) s++;
    end
    wd_kick = 1'b0;
    check("R10 no timeout while kicked", s, 0);
    check("R10 fault_cnt unchanged", fault_cnt, 1);

    // R10 three timeouts then fallback to bank 0
    ncap = 0;
    n = 0;
    while (!busy && n < 200) begin @(negedge clk); n++; end
    wd_en = 1'b0;
    wait_idle();
    check("R10 fault_cnt after three", fault_cnt, 4);
    check("R10 bytes streamed", ncap, IMG);
    s = 1;
    for (int i = 0; i < IMG; i++) if (cap[i] != imgC[i]) s = 0;
    check("R10 fallback image", s, 1);
    check("R10 act_bank switched", act_bank, 0);
    check("R10 err_code", err_code, 2);
    check("R10 rolled", rolled, 1);

    // R11 fallback image bad
    host_cmd(2'd1, 4'd0, 8'h00);
    host_cmd(2'd1, 4'd8, 8'h00);
    ncap = 0;
    wd_en = 1'b1;
    n = 0;
    while (!busy && n < 200) begin @(negedge clk); n++; end
    wd_en = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    check("R11 err_code", err_code, 3);
    check("R11 target held in reset", tgt_rst_n, 0);
    check("R11 act_bank kept", act_bank, 0);
    check("R11 fault_cnt", fault_cnt, 7);
    check("R11 bytes streamed", ncap, IMG);

    check("R6 reset low at every cfg byte", cfg_rst_bad, 0);
    check("R12 single chip select", overlap, 0);
    check("R2 sclk period four clocks", bad_gap, 0);
    check("R2 only known opcodes", seen_bad, 0);
    check("watchdog of bench", wd_fail, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL timeout actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule